// File: doc/BRIEF.md
# Serial Destination Address Matcher

The block sits on the receive side of a mesh router port. Packet bits arrive one at a time, each one flagged by a valid strobe. The block takes the destination address out of that stream while it is still arriving. It checks each address bit against the same bit of the router's own fixed coordinates. When the address is complete, it tells the packet storage unit either to keep the packet or to destroy it.

A packet begins with a one-cycle start pulse. The first valid bit after the pulse is a marker, and it is skipped. The next 16 valid bits are the destination address, most significant bit first. The first 8 of these are the latitude and the last 8 are the longitude. Valid bits after the address are payload, and the matcher ignores them.

The router's coordinates are a static parameter held in a shift register. This register moves one position on every address bit, so its top bit always faces the incoming bit of the same rank. A mismatch latches a sticky bit. At the end of the address, exactly one decision strobe is issued.

Top module: `dest_addr_matcher`

## Requirements
- R1: After reset every flag and strobe output is low, and `phase_o` is 0 (latitude).
- R2: The first valid bit after a packet start is a marker. Its value is never compared, and it does not set `rcv_addr_o`.
- R3: `rcv_addr_o` goes high in the cycle after the first address bit is taken. It stays high until the next packet start.
- R4: `phase_o` is 0 until 8 address bits have been taken, and 1 from then on. While it is 1, the longitude part is being received or has been received.
- R5: Address bit i (MSB first) is compared with bit i of {router latitude, router longitude}. If all 16 bits match, `addr_done_o` rises and `keep_o` pulses in the cycle after the edge that takes the 16th address bit.
- R6: `mismatch_o` goes high in the cycle after the first differing address bit. It stays high until the next packet start. A packet with any mismatch gets exactly one `discard_o` pulse, with the same timing as `keep_o`.
- R7: `keep_o` and `discard_o` are single-cycle pulses and are never high together. At most one of them occurs per packet. Bits after the address cause no strobe and change no flag.
- R8: While `bit_valid_i` is low, `bit_i` is ignored and no counter or flag changes.
- R9: `pkt_start_i` clears both counters, both flags and the mismatch bit, and it reloads the router address register. A packet aborted this way gives no strobe. When start and valid are high in the same cycle, the start wins and the bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pkt_start_i | input | 1 | Packet start pulse |
| bit_valid_i | input | 1 | Qualifies `bit_i` this cycle |
| bit_i | input | 1 | Serial packet bit |
| rcv_addr_o | output | 1 | Address reception has begun |
| phase_o | output | 1 | 0 = latitude part, 1 = longitude part |
| addr_done_o | output | 1 | All address bits received |
| mismatch_o | output | 1 | Sticky: some address bit differed |
| keep_o | output | 1 | One-cycle pulse: keep stored packet |
| discard_o | output | 1 | One-cycle pulse: destroy stored packet |

## Verification
Every flag is registered. Each one is due in the cycle after the clock edge that takes the bit causing it: `rcv_addr_o` after the first address bit, `phase_o` after the 8th, `mismatch_o` after the first differing bit, and both strobes and `addr_done_o` after the 16th. The driver puts a bit on the inputs at the falling edge and checks the flags 5 ns after the next rising edge. It pushes the expected keep or discard decision of each complete packet into a queue. A monitor pops that queue at the same sampling point whenever a strobe is seen, so a late, missing or extra strobe is a mismatch.

// File: rtl/dest_addr_match_pkg.sv
package dest_addr_match_pkg;
  typedef enum logic {
    PH_LAT = 1'b0,
    PH_LON = 1'b1
  } addr_phase_e;

  typedef struct packed {
    logic keep;
    logic discard;
  } verdict_t;
endpackage

// File: rtl/pkt_bit_cnt.sv
// Counts valid packet bits since start; flags the address window.
module pkt_bit_cnt #(
  parameter int ADDR_W = 16,
  localparam int CNT_MAX = ADDR_W + 1,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  output logic in_addr_o
);
  localparam logic [CW-1:0] LIMIT = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (valid_i && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // bit 0 is the marker; bits 1..ADDR_W carry the address
  assign in_addr_o = (cnt_q != '0) && (cnt_q != LIMIT);
endmodule

// File: rtl/addr_bit_cnt.sv
// Counts address bits, reports phase and the final bit.
module addr_bit_cnt
  import dest_addr_match_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int LON_W = 8,
  localparam int ADDR_W = LAT_W + LON_W,
  localparam int CW = $clog2(ADDR_W + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        adv_i,
  output addr_phase_e phase_o,
  output logic        last_o,
  output logic        done_o
);
  localparam logic [CW-1:0] LAT_END = CW'(LAT_W);
  localparam logic [CW-1:0] ALL     = CW'(ADDR_W);
  localparam logic [CW-1:0] LAST    = CW'(ADDR_W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (adv_i && cnt_q != ALL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = (cnt_q >= LAT_END) ? PH_LON : PH_LAT;
  assign last_o  = (cnt_q == LAST);
  assign done_o  = (cnt_q == ALL);
endmodule

// File: rtl/rtr_addr_sreg.sv
// Serializes the static router address, MSB first.
module rtr_addr_sreg #(
  parameter int          W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic shift_i,
  output logic ref_bit_o
);
  logic [W-1:0] q;
  logic [W-1:0] shifted;

  for (genvar i = 0; i < W; i++) begin : g_sh
    if (i == 0) begin : g_lsb
      assign shifted[i] = 1'b0;
    end else begin : g_up
      assign shifted[i] = q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= INIT;
    end else if (load_i) begin
      q <= INIT;
    end else if (shift_i) begin
      q <= shifted;
    end
  end

  assign ref_bit_o = q[W-1];
endmodule

// File: rtl/match_decide.sv
// Sticky mismatch tracking and end-of-address verdict strobes.
module match_decide
  import dest_addr_match_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     adv_i,
  input  logic     bit_i,
  input  logic     ref_bit_i,
  input  logic     last_i,
  output logic     mismatch_o,
  output verdict_t verdict_o
);
  logic     mm_q;
  verdict_t vd_q;
  logic     mm_now;

  assign mm_now = mm_q | (adv_i & (bit_i ^ ref_bit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_q <= 1'b0;
      vd_q <= '0;
    end else if (clr_i) begin
      mm_q <= 1'b0;
      vd_q <= '0;
    end else begin
      mm_q         <= mm_now;
      vd_q.keep    <= adv_i & last_i & ~mm_now;
      vd_q.discard <= adv_i & last_i & mm_now;
    end
  end

  assign mismatch_o = mm_q;
  assign verdict_o  = vd_q;
endmodule

// File: rtl/dest_addr_matcher.sv
module dest_addr_matcher
  import dest_addr_match_pkg::*;
#(
  parameter int               LAT_W   = 8,
  parameter int               LON_W   = 8,
  parameter logic [LAT_W-1:0] RTR_LAT = 8'h5A,
  parameter logic [LON_W-1:0] RTR_LON = 8'hC3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pkt_start_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic rcv_addr_o,
  output logic phase_o,
  output logic addr_done_o,
  output logic mismatch_o,
  output logic keep_o,
  output logic discard_o
);
  localparam int ADDR_W = LAT_W + LON_W;
  localparam logic [ADDR_W-1:0] RTR_ADDR = {RTR_LAT, RTR_LON};

  logic        take;
  logic        in_addr;
  logic        addr_bit;
  logic        ref_bit;
  logic        last;
  logic        done;
  addr_phase_e phase;
  verdict_t    verdict;
  logic        rcv_q;

  assign take     = bit_valid_i & ~pkt_start_i;
  assign addr_bit = take & in_addr;

  pkt_bit_cnt #(.ADDR_W(ADDR_W)) u_pkt_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pkt_start_i),
    .valid_i   (take),
    .in_addr_o (in_addr)
  );

  addr_bit_cnt #(.LAT_W(LAT_W), .LON_W(LON_W)) u_addr_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (pkt_start_i),
    .adv_i   (addr_bit),
    .phase_o (phase),
    .last_o  (last),
    .done_o  (done)
  );

  rtr_addr_sreg #(.W(ADDR_W), .INIT(RTR_ADDR)) u_sreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (pkt_start_i),
    .shift_i   (addr_bit),
    .ref_bit_o (ref_bit)
  );

  match_decide u_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pkt_start_i),
    .adv_i      (addr_bit),
    .bit_i      (bit_i),
    .ref_bit_i  (ref_bit),
    .last_i     (last),
    .mismatch_o (mismatch_o),
    .verdict_o  (verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcv_q <= 1'b0;
    end else if (pkt_start_i) begin
      rcv_q <= 1'b0;
    end else if (addr_bit) begin
      rcv_q <= 1'b1;
    end
  end

  assign rcv_addr_o  = rcv_q;
  assign phase_o     = (phase == PH_LON);
  assign addr_done_o = done;
  assign keep_o      = verdict.keep;
  assign discard_o   = verdict.discard;
endmodule

// File: rtl/dest_addr_matcher_chk.sv
module dest_addr_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pkt_start_i,
  input logic bit_valid_i,
  input logic rcv_addr_o,
  input logic phase_o,
  input logic addr_done_o,
  input logic mismatch_o,
  input logic keep_o,
  input logic discard_o
);
  a_r7_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(keep_o && discard_o));

  a_r7_keep_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_o |=> !keep_o);

  a_r7_discard_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |=> !discard_o);

  a_r5_done_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_done_o) |-> (keep_o ^ discard_o));

  a_r5_keep_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_o |-> (!mismatch_o && addr_done_o));

  a_r6_discard_mm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> (mismatch_o && addr_done_o));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_o && !pkt_start_i) |=> mismatch_o);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcv_addr_o && !pkt_start_i) |=> rcv_addr_o);

  a_r4_done_lon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_o |-> (phase_o && rcv_addr_o));

  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && !pkt_start_i) |=> ($stable(rcv_addr_o) && $stable(mismatch_o)
                                        && $stable(phase_o)));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_i |=> (!rcv_addr_o && !addr_done_o && !mismatch_o && !phase_o
                     && !keep_o && !discard_o));
endmodule

bind dest_addr_matcher dest_addr_matcher_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_start_i (pkt_start_i),
  .bit_valid_i (bit_valid_i),
  .rcv_addr_o  (rcv_addr_o),
  .phase_o     (phase_o),
  .addr_done_o (addr_done_o),
  .mismatch_o  (mismatch_o),
  .keep_o      (keep_o),
  .discard_o   (discard_o)
);

// File: tb/dest_addr_matcher_bench.sv
`timescale 1ns/1ps
module dest_addr_matcher_bench;
  localparam logic [7:0]  R_LAT = 8'h5A;
  localparam logic [7:0]  R_LON = 8'hC3;
  localparam logic [15:0] R_ADDR = {R_LAT, R_LON};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic rcv_addr, phase, addr_done, mismatch, keep, discard;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit exp_q[$];   // 1 = keep, 0 = discard

  always #10 clk = ~clk;

  dest_addr_matcher #(.RTR_LAT(R_LAT), .RTR_LON(R_LON)) u_dest_addr_matcher (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pkt_start_i (pkt_start),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_in),
    .rcv_addr_o  (rcv_addr),
    .phase_o     (phase),
    .addr_done_o (addr_done),
    .mismatch_o  (mismatch),
    .keep_o      (keep),
    .discard_o   (discard)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, return 5 ns after the rising edge that took it
  task automatic step(input logic v, input logic b, input logic s);
    @(negedge clk);
    pkt_start = s;
    bit_valid = v;
    bit_in    = b;
    @(posedge clk);
    #5;
    pkt_start = 1'b0;
    bit_valid = 1'b0;
  endtask

  // n_addr < 16 leaves the packet unfinished (no verdict expected)
  task automatic send_pkt(input logic [7:0] lat, input logic [7:0] lon, input logic marker,
                          input int gap, input int n_addr, input int trail,
                          input logic start_with_valid);
    logic [15:0] a;
    logic exp_mm;
    a = {lat, lon};
    exp_mm = 1'b0;
    step(start_with_valid, 1'b1, 1'b1);
    chk("R9 start clears", {rcv_addr, phase, addr_done, mismatch, keep, discard}, 0);
    step(1'b1, marker, 1'b0);
    chk("R2 marker no rcv", {rcv_addr, mismatch}, 0);
    if (n_addr == 16) exp_q.push_back(a == R_ADDR);
    for (int i = 0; i < n_addr; i++) begin
      step(1'b1, a[15-i], 1'b0);
      exp_mm = exp_mm | (a[15-i] != R_ADDR[15-i]);
      chk("R3 rcv after addr bit", rcv_addr, 1);
      chk("R4 phase", phase, (i + 1 >= 8));
      chk("R6 mismatch", mismatch, exp_mm);
      chk("R5 done", addr_done, (i == 15));
      for (int g = 0; g < gap; g++) begin
        step(1'b0, ~a[15-i], 1'b0);
        chk("R8 idle holds", {rcv_addr, phase, mismatch}, {1'b1, (i + 1 >= 8), exp_mm});
      end
    end
    for (int t = 0; t < trail; t++) begin
      step(1'b1, t[0] ^ ~R_ADDR[t % 16], 1'b0);
      chk("R7 trailing bits ignored", {rcv_addr, phase, addr_done, mismatch},
          {3'b111, exp_mm});
    end
    repeat (2) step(1'b0, 1'b0, 1'b0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && (keep || discard)) begin
        n_chk++;
        if (keep && discard) begin
          n_fail++;
          $display("FAIL R7 both strobes act=11 exp=one");
        end else if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R7 unexpected strobe act=keep%0b/discard%0b exp=none", keep, discard);
        end else begin
          bit e;
          e = exp_q.pop_front();
          if (keep !== e) begin
            n_fail++;
            $display("FAIL R5/R6 verdict act=keep%0b exp=keep%0b", keep, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rcv_addr, phase, addr_done, mismatch, keep, discard}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset release", {rcv_addr, phase, addr_done, mismatch, keep, discard}, 0);

    send_pkt(R_LAT, R_LON, 1'b1, 0, 16, 0, 1'b0);            // R5 keep
    send_pkt(R_LAT ^ 8'h80, R_LON, 1'b1, 0, 16, 0, 1'b0);    // R6 first bit differs
    send_pkt(R_LAT, R_LON ^ 8'h01, 1'b1, 0, 16, 0, 1'b0);    // R6 last bit differs
    send_pkt(R_LAT, R_LON, 1'b0, 0, 16, 0, 1'b0);            // R2 marker value ignored
    send_pkt(R_LAT, R_LON, 1'b1, 2, 16, 0, 1'b0);            // R8 gaps with junk data
    send_pkt(R_LAT, R_LON, 1'b1, 0, 16, 20, 1'b0);           // R7 trailing payload
    send_pkt(~R_LAT, ~R_LON, 1'b1, 1, 16, 5, 1'b0);          // R6 many mismatches, one strobe
    send_pkt(R_LAT ^ 8'h02, R_LON, 1'b1, 0, 10, 0, 1'b0);    // R9 aborted packet
    send_pkt(R_LAT, R_LON, 1'b1, 0, 16, 0, 1'b1);            // R9 start beats valid
    send_pkt(R_LAT, 8'h00, 1'b1, 0, 16, 0, 1'b0);            // R6 longitude only

    repeat (4) step(1'b0, 1'b0, 1'b0);
    chk("R7 all verdicts seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule